// File: doc/BRIEF.md
# Serial ADC Responder (Converter Side of a 16-Clock Link)

This block plays the converter's part of a four-wire serial link: chip select (active low), a serial clock, a data line into the converter and a data line out of it. Eight parallel 12-bit sample words stand in for eight analog inputs. In every frame the block shifts out the word of the channel that was chosen during the previous frame. While doing so it reads the channel number for the next frame from the incoming data line. It is meant as a synthesizable responder for a link master, or as a partner that checks one.

All link inputs are oversampled by the block's own clock. Each input passes through a short synchronizer and is then edge-detected. Each high and low phase of the serial clock must last at least `SYNC_STAGES + 3` system clocks. The selected word is captured when chip select falls. A channel number received in a frame takes effect only after that frame has run all sixteen serial clocks.

Top module: `adc_link_responder`

## Requirements
- R1: After reset the committed channel is 0, `dout_oe` is 0 and `dout` is 0, so the first frame returns the word of channel 0.
- R2: `din` is sampled on the first 8 rising serial clock edges of a frame, most significant bit first. Rising edges 3, 4 and 5 give channel bits 2, 1 and 0, which are bits 5:3 of the byte sent. The other five bits have no effect.
- R3: A channel number received in frame N selects the output word of frame N+1 only. It never alters the word being sent in frame N.
- R4: Within a frame, `dout` is 0 after falling serial clock edges 1 to 3. It carries word bits 11 down to 0 after falling edges 4 to 15, one bit per edge, and is 0 after falling edge 16.
- R5: The selected 12-bit word is captured when chip select falls. Changes on `samples` during the frame do not change the bits that are shifted out.
- R6: A frame that ends with fewer than 16 rising serial clock edges leaves the committed channel unchanged.
- R7: `dout_oe` is 1 while chip select is low (after the synchronizer delay) and 0 otherwise. `dout` is 0 whenever `dout_oe` is 0.
- R8: During a frame, `dout` changes only in response to a falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; a frame runs while it is low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial control data into the converter |
| samples | input | 96 | Eight 12-bit words; channel c occupies bits 12c+11 to 12c |
| dout | output | 1 | Serial result data, 0 when not enabled |
| dout_oe | output | 1 | Output enable for `dout` (stands for the high-impedance state) |

## Verification
The embedded assertions check the cycle-level rules on every clock. The committed channel changes only as chip select rises and never after a short frame. `dout` holds between falling serial edges. `dout` is 0 whenever the output enable is low, and reset clears the channel. Only the bench scenarios can show the end-to-end behaviour. These cover the one-frame delay of the channel through a chain of frames, the exact bit layout of the 16-clock word, and that the don't-care control bits are ignored. They also show that a word changed mid-frame does not leak into the output, and that aborts after 5 and after 15 clocks keep the old channel.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    localparam int unsigned CH_N         = 8;
    localparam int unsigned DATA_W       = 12;
    localparam int unsigned FRAME_CLKS   = 16;
    localparam int unsigned LEAD_ZEROS   = 4;
    localparam int unsigned CAPTURE_CLKS = 8;
    localparam int unsigned ADDR_FIRST   = 3;
    localparam int unsigned SYNC_STAGES  = 2;

    // Decoded link events, one system clock wide each
    typedef struct packed {
        logic cs_active;
        logic cs_fall;
        logic cs_rise;
        logic sclk_rise;
        logic sclk_fall;
        logic din;
    } link_evt_t;

    // Where in the frame a given falling edge lies
    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2
    } out_phase_e;

    function automatic out_phase_e edge_phase(input int edge_no,
                                              input int lead,
                                              input int width);
        if (edge_no < lead)
            return PH_LEAD;
        else if (edge_no < lead + width)
            return PH_DATA;
        else
            return PH_TAIL;
    endfunction

endpackage

// File: rtl/link_sync.sv
module link_sync
    import adc_link_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sclk,
    input  logic      din,
    output link_evt_t evt
);
    // bit 2: cs_n, bit 1: sclk, bit 0: din
    localparam logic [2:0] IDLE_LVL = 3'b110;

    logic [2:0] raw;
    logic [2:0] sr [STAGES];
    logic [2:0] prev;
    logic [2:0] cur;

    assign raw = {cs_n, sclk, din};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sr[g] <= IDLE_LVL;
                else     sr[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sr[g] <= IDLE_LVL;
                else     sr[g] <= sr[g-1];
            end
        end
    end

    assign cur = sr[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= IDLE_LVL;
        else     prev <= cur;
    end

    always_comb begin
        evt.cs_active = ~cur[2];
        evt.cs_fall   = prev[2] & ~cur[2];
        evt.cs_rise   = ~prev[2] & cur[2];
        evt.sclk_rise = ~prev[1] & cur[1] & ~cur[2];
        evt.sclk_fall = prev[1] & ~cur[1] & ~cur[2];
        evt.din       = cur[0];
    end

endmodule

// File: rtl/ctrl_capture.sv
module ctrl_capture
    import adc_link_pkg::*;
#(
    parameter int unsigned CAP_CLKS  = CAPTURE_CLKS,
    parameter int unsigned FRAME_N   = FRAME_CLKS,
    parameter int unsigned ADDR_POS  = ADDR_FIRST,
    parameter int unsigned ADDR_W    = $clog2(CH_N),
    parameter int unsigned CNT_W     = $clog2(FRAME_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              din,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int unsigned ADDR_HI = CAP_CLKS - ADDR_POS;
    localparam int unsigned ADDR_LO = ADDR_HI - ADDR_W + 1;

    logic [CAP_CLKS-1:0] cap_q;
    logic [CNT_W-1:0]    rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            rise_cnt <= '0;
            addr_q   <= '0;
        end else if (cs_fall) begin
            cap_q    <= '0;
            rise_cnt <= '0;
        end else if (sclk_rise) begin
            if (rise_cnt < CNT_W'(CAP_CLKS))
                cap_q <= {cap_q[CAP_CLKS-2:0], din};
            if (rise_cnt < CNT_W'(FRAME_N))
                rise_cnt <= rise_cnt + 1'b1;
        end else if (cs_rise) begin
            if (rise_cnt == CNT_W'(FRAME_N))
                addr_q <= cap_q[ADDR_HI:ADDR_LO];
        end
    end

    // R1
    reset_addr_chk: assert property (@(posedge clk) rst |=> addr_q == '0);

    // R3
    commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_q) |-> $past(cs_rise));

    // R6
    short_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && rise_cnt != CNT_W'(FRAME_N)) |=> $stable(addr_q));

    // R2
    rise_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rise_cnt <= CNT_W'(FRAME_N));

endmodule

// File: rtl/sample_shifter.sv
module sample_shifter
    import adc_link_pkg::*;
#(
    parameter int unsigned NCH     = CH_N,
    parameter int unsigned DW      = DATA_W,
    parameter int unsigned FRAME_N = FRAME_CLKS,
    parameter int unsigned LEAD_N  = LEAD_ZEROS,
    parameter int unsigned ADDR_W  = $clog2(CH_N),
    parameter int unsigned CNT_W   = $clog2(FRAME_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [NCH*DW-1:0] samples,
    output logic              dout_q,
    output logic              oe_q
);
    logic [DW-1:0]    ch_word [NCH];
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] fall_cnt;
    out_phase_e       ph;

    for (genvar g = 0; g < NCH; g++) begin : g_word
        assign ch_word[g] = samples[g*DW +: DW];
    end

    always_comb ph = edge_phase(int'(fall_cnt) + 1, int'(LEAD_N), int'(DW));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            fall_cnt <= '0;
            dout_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            oe_q <= cs_active;
            if (!cs_active) begin
                dout_q <= 1'b0;
            end else if (cs_fall) begin
                shreg    <= ch_word[addr_q];
                fall_cnt <= '0;
                dout_q   <= 1'b0;
            end else if (sclk_fall) begin
                if (fall_cnt < CNT_W'(FRAME_N))
                    fall_cnt <= fall_cnt + 1'b1;
                if (ph == PH_DATA) begin
                    dout_q <= shreg[DW-1];
                    shreg  <= {shreg[DW-2:0], 1'b0};
                end else begin
                    dout_q <= 1'b0;
                end
            end
        end
    end

    // R8
    hold_between_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_active && !cs_fall && !sclk_fall) |=> $stable(dout_q));

    // R4
    fall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fall_cnt <= CNT_W'(FRAME_N));

endmodule

// File: rtl/adc_link_responder.sv
module adc_link_responder
    import adc_link_pkg::*;
#(
    parameter int unsigned NCH      = CH_N,
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned FRAME_N  = FRAME_CLKS,
    parameter int unsigned LEAD_N   = LEAD_ZEROS,
    parameter int unsigned CAP_N    = CAPTURE_CLKS,
    parameter int unsigned ADDR_POS = ADDR_FIRST,
    parameter int unsigned SYNC_N   = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [NCH*DW-1:0] samples,
    output logic              dout,
    output logic              dout_oe
);
    localparam int unsigned ADDR_W = $clog2(NCH);
    localparam int unsigned CNT_W  = $clog2(FRAME_N + 1);

    link_evt_t         evt;
    logic [ADDR_W-1:0] addr_q;

    link_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .din  (din),
        .evt  (evt)
    );

    ctrl_capture #(
        .CAP_CLKS (CAP_N),
        .FRAME_N  (FRAME_N),
        .ADDR_POS (ADDR_POS),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .cs_fall   (evt.cs_fall),
        .cs_rise   (evt.cs_rise),
        .sclk_rise (evt.sclk_rise),
        .din       (evt.din),
        .addr_q    (addr_q)
    );

    sample_shifter #(
        .NCH     (NCH),
        .DW      (DW),
        .FRAME_N (FRAME_N),
        .LEAD_N  (LEAD_N),
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_active (evt.cs_active),
        .cs_fall   (evt.cs_fall),
        .sclk_fall (evt.sclk_fall),
        .addr_q    (addr_q),
        .samples   (samples),
        .dout_q    (dout),
        .oe_q      (dout_oe)
    );

    // R7
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> !dout);

    // R7
    oe_follows_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $past(evt.cs_active) |-> dout_oe);

endmodule

// File: tb/adc_link_responder_tb.sv
module adc_link_responder_tb;

    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int NCH   = 8;
    localparam int DW    = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b1;
    logic              din = 1'b0;
    logic [NCH*DW-1:0] samples;
    logic              dout;
    logic              dout_oe;

    logic [DW-1:0] smp [NCH];
    int            vectors = 0;
    int            misses  = 0;
    bit            done    = 0;
    logic [2:0]    exp_addr = 3'd0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) samples[i*DW +: DW] = smp[i];
    end

    adc_link_responder u_dut (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .din     (din),
        .samples (samples),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    function automatic logic [15:0] frame_word(input logic [DW-1:0] s);
        return {3'b000, s, 1'b0};
    endfunction

    function automatic logic [7:0] ctl_byte(input logic [2:0] a, input bit fill);
        return fill ? {2'b11, a, 3'b111} : {2'b00, a, 3'b000};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] ctl, input int n_clk, input bit disturb,
                             input int ch, output logic [15:0] got, output logic oe_mid);
        got    = '0;
        oe_mid = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 1; k <= n_clk; k++) begin
            sclk = 1'b0;
            din  = (k <= 8) ? ctl[8-k] : 1'b0;
            repeat (6) @(negedge clk);
            got[16-k] = dout;
            if (k == 8) oe_mid = dout_oe;
            if (disturb && k == 2) smp[ch] = ~smp[ch];
            repeat (HALF - 6) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        din  = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic frame_chk(input logic [7:0] ctl, input string tag);
        logic [15:0] got;
        logic        oe;
        run_frame(ctl, 16, 1'b0, 0, got, oe);
        check(tag, got, frame_word(smp[exp_addr]));
        exp_addr = ctl[5:3];
    endtask

    task automatic t_reset;
        logic [15:0] got;
        logic        oe;
        check("R1 oe after reset", {15'b0, dout_oe}, 16'h0);
        check("R1 dout after reset", {15'b0, dout}, 16'h0);
        run_frame(ctl_byte(3'd5, 0), 16, 1'b0, 0, got, oe);
        check("R1 R4 first frame is channel 0", got, frame_word(smp[0]));
        check("R7 oe during frame", {15'b0, oe}, 16'h1);
        check("R7 oe after frame", {15'b0, dout_oe}, 16'h0);
        check("R7 dout after frame", {15'b0, dout}, 16'h0);
        exp_addr = 3'd5;
    endtask

    task automatic t_chain;
        frame_chk(ctl_byte(3'd2, 0), "R3 chain a");
        frame_chk(ctl_byte(3'd7, 0), "R3 chain b");
        frame_chk(ctl_byte(3'd0, 0), "R3 chain c");
        frame_chk(ctl_byte(3'd3, 0), "R3 chain d");
        frame_chk(ctl_byte(3'd6, 0), "R4 chain e");
    endtask

    task automatic t_ignore;
        frame_chk(ctl_byte(3'd2, 1), "R2 fill ones");
        frame_chk(8'b1100_0111, "R2 fill ones addr 2");
        frame_chk(ctl_byte(3'd4, 0), "R2 fill ones addr 0");
    endtask

    task automatic t_abort;
        logic [15:0] got;
        logic        oe;
        run_frame(ctl_byte(3'd1, 0), 5, 1'b0, 0, got, oe);
        frame_chk(ctl_byte(3'd6, 0), "R6 abort after 5");
        run_frame(ctl_byte(3'd1, 0), 15, 1'b0, 0, got, oe);
        check("R6 dout after abort", {15'b0, dout}, 16'h0);
        frame_chk(ctl_byte(3'd3, 0), "R6 abort after 15");
    endtask

    task automatic t_latch;
        logic [15:0] got;
        logic        oe;
        logic [DW-1:0] orig;
        int ch;
        ch   = int'(exp_addr);
        orig = smp[ch];
        run_frame(ctl_byte(3'd7, 0), 16, 1'b1, ch, got, oe);
        check("R5 word held from cs fall", got, frame_word(orig));
        exp_addr = 3'd7;
        smp[7] = 12'h801;
        frame_chk(ctl_byte(3'd1, 0), "R5 next frame sees new word");
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) smp[i] = 12'h9A5 ^ 12'(i * 12'h137);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset;
        t_chain;
        t_ignore;
        t_abort;
        t_latch;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule